// File: doc/BRIEF.md
# Serial Command Port with Operation Interrupt

This block is the host-facing serial port of a message record and playback controller. A host acting as SPI master selects the port by pulling the active-low select line down. It then clocks a 16-bit command in on the data input. On the same clock edges, the port returns a 16-bit status word on the data output. Both directions move least significant bit first. The incoming word splits into an 11-bit message address and a 5-bit control field. Neither field reaches the controller until select goes high again, and then only if exactly 16 clock bits arrived.

One control bit is the run request. A valid command with run set starts an operation: the run output rises and a single-cycle start pulse is issued. A valid command with run clear stops any operation without raising an interrupt. The storage side reports the end of an operation with two strobes, end-of-message and overflow. Either strobe, while an operation is running, stops it, records which condition ended it, and drives the active-low interrupt. The interrupt and the recorded flags are cleared as each new frame begins. They are first copied into the status word for that frame, so the host can read why the last operation ended and launch the next one in the same frame. The serial clock and select are brought into the system clock domain through two-flop synchronisers.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, `int_n` is high, `run` and `start_pulse` are low, `cmd_addr` and `cmd_ctrl` are zero, and `miso_oe` is low.
- R2: MOSI is sampled on rising SCLK edges, least significant bit first. After a valid frame, frame bits 10..0 appear on `cmd_addr` and frame bits 15..11 appear on `cmd_ctrl`.
- R3: While select is low, `cmd_addr`, `cmd_ctrl` and `run` do not change as a result of the frame. A frame takes effect only after select rises.
- R4: A frame whose select rises after any number of rising SCLK edges other than 16 is discarded. The latched command and `run` keep their values.
- R5: The run request is control bit 0, which is frame bit 11. A valid frame with it set raises `run` and gives a one-cycle `start_pulse`. A valid frame with it clear lowers `run`, with no start pulse and no interrupt.
- R6: An end-of-message or overflow strobe while `run` is high lowers `run`, records the condition, and drives `int_n` low.
- R7: End strobes while `run` is low have no effect on `int_n`, `run` or the status flags.
- R8: The pending interrupt and both status flags clear when a new frame starts, which is the falling edge of select.
- R9: The status word has the overflow flag in bit 0, the end-of-message flag in bit 1, zero in bits 4..2 and the current command address in bits 15..5. It is captured at the falling edge of select. Bit 0 is presented first, and MISO advances one bit on each falling SCLK edge.
- R10: `miso_oe` is high only while the synchronised select is low.
- R11: A single frame can both return the flags of the operation that just ended and start a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ss_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial command data from the host |
| miso | output | 1 | Serial status data to the host |
| miso_oe | output | 1 | Drive enable for the MISO pad; low means high impedance |
| eom_in | input | 1 | End-of-message strobe from the storage side |
| ovf_in | input | 1 | Overflow strobe from the storage side |
| cmd_addr | output | 11 | Latched message address |
| cmd_ctrl | output | 5 | Latched control field |
| run | output | 1 | Operation in progress |
| start_pulse | output | 1 | One-cycle pulse when an operation is launched |
| int_n | output | 1 | Active-low interrupt for an operation that ended |

## Verification
The hardest situation to reach is the overlapped frame: an interrupt is pending, and the next frame must both read out the flags that caused it and start a new operation. The flags are copied and cleared on the same clock edge. The stimulus first runs an operation and ends it with an end strobe. It then sends a frame that carries the run request, and compares the 16 bits returned on MISO against the expected flag pattern while the new run begins. Frames of 15 and 17 clock bits are also sent to show that an improper frame leaves the latched command alone.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the serial command port.
// Assumes: frame = address field in the low bits, control field above it.
package spi_cmd_pkg;

    localparam int DEF_ADDR_W   = 11;
    localparam int DEF_CTRL_W   = 5;
    localparam int DEF_RUN_IDX  = 0;
    localparam int DEF_SYNC_STG = 2;

    // Conditions that can end an operation; also the low two status bits.
    typedef struct packed {
        logic eom;
        logic ovf;
    } end_flags_t;

endpackage

// File: rtl/spi_in_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a bus of asynchronous single-bit inputs.
// Assumes: each bit is independent (no bus coherence needed); reset value
// per bit is given so idle levels are correct out of reset.
module spi_in_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop samples the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Later flops resolve metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/spi_frame_shifter.sv
`timescale 1ns/1ps
// Frame engine: detects select and clock edges in the system domain,
// shifts the command in LSB first on clock rises, shifts status out LSB
// first on clock falls, and counts bits to judge the frame at its end.
// Assumes: inputs are already synchronised; system clock is several times
// faster than the serial clock so no edge is missed.
module spi_frame_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ss_n_s,
    input  logic               sclk_s,
    input  logic               mosi_s,
    input  logic [FRAME_W-1:0] status_word,
    output logic               frame_start,
    output logic               frame_end,
    output logic               frame_ok,
    output logic [FRAME_W-1:0] frame_data,
    output logic               miso,
    output logic               miso_oe
);

    localparam int                CNT_W    = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0]  CNT_SAT  = CNT_W'(FRAME_W + 1);

    logic               ss_d, sclk_d;
    logic               sclk_rise, sclk_fall, in_frame;
    logic [FRAME_W-1:0] rx_q, tx_q;
    logic [CNT_W-1:0]   cnt_q;

    // Delayed copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            ss_d   <= ss_n_s;
            sclk_d <= sclk_s;
        end
    end

    assign frame_start = ss_d & ~ss_n_s;
    assign frame_end   = ~ss_d & ss_n_s;
    assign in_frame    = ~ss_n_s;
    assign sclk_rise   = in_frame & sclk_s & ~sclk_d;
    assign sclk_fall   = in_frame & ~sclk_s & sclk_d;

    // Receive shift register and saturating bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (frame_start) begin
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (sclk_rise) begin
            rx_q  <= {mosi_s, rx_q[FRAME_W-1:1]};
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Transmit register: load status at frame start, advance on clock falls.
    always_ff @(posedge clk) begin
        if (!rst_n)           tx_q <= '0;
        else if (frame_start) tx_q <= status_word;
        else if (sclk_fall)   tx_q <= {1'b0, tx_q[FRAME_W-1:1]};
    end

    assign frame_ok   = (cnt_q == CNT_FULL);
    assign frame_data = rx_q;
    assign miso       = tx_q[0];
    assign miso_oe    = ~ss_d;

    // R9
    status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (miso == $past(status_word[0])));

    // R10
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !miso_oe);

endmodule

// File: rtl/spi_op_ctrl.sv
`timescale 1ns/1ps
// Operation control: latches a validated command at frame end, owns the
// run state, records end conditions, drives the interrupt and builds the
// status word.
// Assumes: frame_start/frame_end are single-cycle pulses; end strobes are
// synchronous to clk.
module spi_op_ctrl
    import spi_cmd_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int CTRL_W  = DEF_CTRL_W,
    parameter int RUN_IDX = DEF_RUN_IDX
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic                      frame_end,
    input  logic                      frame_ok,
    input  logic [ADDR_W+CTRL_W-1:0]  frame_data,
    input  logic                      eom_in,
    input  logic                      ovf_in,
    output logic [ADDR_W-1:0]         cmd_addr,
    output logic [CTRL_W-1:0]         cmd_ctrl,
    output logic                      run,
    output logic                      start_pulse,
    output logic                      int_n,
    output logic [ADDR_W+CTRL_W-1:0]  status_word
);

    localparam int FRAME_W = ADDR_W + CTRL_W;
    localparam int PAD_W   = FRAME_W - ADDR_W - 2;

    logic        cmd_load, run_req, end_evt;
    end_flags_t  flags_q, flags_nxt;

    assign cmd_load = frame_end & frame_ok;
    assign run_req  = frame_data[ADDR_W + RUN_IDX];
    assign end_evt  = run & (eom_in | ovf_in);

    // Command latch: only a complete frame replaces the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_addr <= '0;
            cmd_ctrl <= '0;
        end else if (cmd_load) begin
            cmd_addr <= frame_data[ADDR_W-1:0];
            cmd_ctrl <= frame_data[FRAME_W-1:ADDR_W];
        end
    end

    // Run state and launch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run         <= 1'b0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= cmd_load & run_req;
            if (cmd_load)     run <= run_req;
            else if (end_evt) run <= 1'b0;
        end
    end

    // Next flag value: clear at frame start, then set by an ending event.
    always_comb begin
        flags_nxt = flags_q;
        if (frame_start) flags_nxt = '0;
        if (end_evt) begin
            flags_nxt.eom = flags_nxt.eom | eom_in;
            flags_nxt.ovf = flags_nxt.ovf | ovf_in;
        end
    end

    // Flag and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            int_n   <= 1'b1;
        end else begin
            flags_q <= flags_nxt;
            int_n   <= ~(flags_nxt.eom | flags_nxt.ovf);
        end
    end

    assign status_word = {cmd_addr, {PAD_W{1'b0}}, flags_q.eom, flags_q.ovf};

    // R8
    int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !(eom_in || ovf_in)) |=> int_n);

    // R5
    run_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> start_pulse);

    // R3 R4
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_end && frame_ok) |=> ($stable(cmd_addr) && $stable(cmd_ctrl)));

    // R6
    int_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> $past(run));

    // R7
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && int_n) |=> int_n);

endmodule

// File: rtl/spi_cmd_slave.sv
`timescale 1ns/1ps
// Top of the serial command port: synchronises the host pins, runs the
// frame engine and the operation control.
// Assumes: system clock at least 4x the serial clock; MISO pad tri-state
// is built outside from miso/miso_oe.
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int CTRL_W   = DEF_CTRL_W,
    parameter int RUN_IDX  = DEF_RUN_IDX,
    parameter int SYNC_STG = DEF_SYNC_STG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_n,
    input  logic              sclk,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    input  logic              eom_in,
    input  logic              ovf_in,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [CTRL_W-1:0] cmd_ctrl,
    output logic              run,
    output logic              start_pulse,
    output logic              int_n
);

    localparam int FRAME_W = ADDR_W + CTRL_W;

    logic [2:0]         pins_s;
    logic               frame_start, frame_end, frame_ok;
    logic [FRAME_W-1:0] frame_data, status_word;

    spi_in_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STG),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ss_n, sclk, mosi}),
        .q_sync  (pins_s)
    );

    spi_frame_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .ss_n_s      (pins_s[2]),
        .sclk_s      (pins_s[1]),
        .mosi_s      (pins_s[0]),
        .status_word (status_word),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .frame_ok    (frame_ok),
        .frame_data  (frame_data),
        .miso        (miso),
        .miso_oe     (miso_oe)
    );

    spi_op_ctrl #(
        .ADDR_W  (ADDR_W),
        .CTRL_W  (CTRL_W),
        .RUN_IDX (RUN_IDX)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .frame_ok    (frame_ok),
        .frame_data  (frame_data),
        .eom_in      (eom_in),
        .ovf_in      (ovf_in),
        .cmd_addr    (cmd_addr),
        .cmd_ctrl    (cmd_ctrl),
        .run         (run),
        .start_pulse (start_pulse),
        .int_n       (int_n),
        .status_word (status_word)
    );

endmodule

// File: tb/spi_cmd_slave_tb.sv
`timescale 1ns/1ps
module spi_cmd_slave_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ss_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic        eom_in = 1'b0, ovf_in = 1'b0;
    logic        miso, miso_oe, run, start_pulse, int_n;
    logic [10:0] cmd_addr;
    logic [4:0]  cmd_ctrl;

    always #10 clk = ~clk;

    spi_cmd_slave u_dut (
        .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .eom_in(eom_in), .ovf_in(ovf_in),
        .cmd_addr(cmd_addr), .cmd_ctrl(cmd_ctrl), .run(run),
        .start_pulse(start_pulse), .int_n(int_n)
    );

    int checks = 0, failures = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: timed events in a queue, applied per clock.
    typedef struct {
        int          due;
        int          kind;   // 0 select fall, 1 select rise, 2 end strobe
        logic [15:0] data;
        int          nbits;
    } ev_t;
    ev_t evq[$];

    int          cyc = 0;
    logic [10:0] e_addr;
    logic [4:0]  e_ctrl;
    logic        e_run, e_start, e_int_n, e_eom, e_ovf, e_oe;
    logic [15:0] e_status;
    int          pulses = 0;

    always @(posedge clk) begin
        cyc++;
        e_start = 1'b0;
        if (!rst_n) begin
            e_addr = '0; e_ctrl = '0; e_run = 0; e_int_n = 1;
            e_eom = 0; e_ovf = 0; e_oe = 0; e_status = '0;
            evq.delete();
        end else begin
            for (int i = evq.size() - 1; i >= 0; i--) begin
                if (evq[i].due == cyc) begin
                    case (evq[i].kind)
                        0: begin
                            e_status = {e_addr, 3'b000, e_eom, e_ovf};
                            e_eom = 0; e_ovf = 0; e_int_n = 1; e_oe = 1;
                        end
                        1: begin
                            e_oe = 0;
                            if (evq[i].nbits == 16) begin
                                e_addr  = evq[i].data[10:0];
                                e_ctrl  = evq[i].data[15:11];
                                e_run   = evq[i].data[11];
                                e_start = evq[i].data[11];
                            end
                        end
                        default: begin
                            if (e_run) begin
                                e_eom = e_eom | evq[i].data[1];
                                e_ovf = e_ovf | evq[i].data[0];
                                e_run = 0;
                                e_int_n = 0;
                            end
                        end
                    endcase
                    evq.delete(i);
                end
            end
        end
    end

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cmd_addr === e_addr, "R2", "cmd_addr", 32'(cmd_addr), 32'(e_addr));
            chk(cmd_ctrl === e_ctrl, "R2", "cmd_ctrl", 32'(cmd_ctrl), 32'(e_ctrl));
            chk(run === e_run, "R5", "run", 32'(run), 32'(e_run));
            chk(start_pulse === e_start, "R5", "start_pulse", 32'(start_pulse), 32'(e_start));
            chk(int_n === e_int_n, "R6", "int_n", 32'(int_n), 32'(e_int_n));
            chk(miso_oe === e_oe, "R10", "miso_oe", 32'(miso_oe), 32'(e_oe));
            if (start_pulse === 1'b1) pulses++;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [15:0] w, input int nbits,
                              output logic [15:0] got);
        logic [10:0] addr0;
        ev_t ev;
        addr0 = cmd_addr;
        got = '0;
        ss_n = 1'b0;
        ev.due = cyc + 3; ev.kind = 0; ev.data = '0; ev.nbits = 0;
        evq.push_back(ev);
        wait_clk(4);
        chk(int_n === 1'b1, "R8", "int_n after frame start", 32'(int_n), 32'd1);
        chk(miso_oe === 1'b1, "R10", "miso_oe in frame", 32'(miso_oe), 32'd1);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? w[i] : 1'b1;
            wait_clk(2);
            if (i < 16) begin
                got[i] = miso;
                chk(miso === e_status[i], "R9", "miso bit", 32'(miso), 32'(e_status[i]));
            end
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(2);
            if (i == 7)
                chk(cmd_addr === addr0, "R3", "cmd_addr mid-frame", 32'(cmd_addr), 32'(addr0));
        end
        wait_clk(2);
        chk(cmd_addr === addr0, "R3", "cmd_addr before select rise", 32'(cmd_addr), 32'(addr0));
        ss_n = 1'b1;
        mosi = 1'b0;
        ev.due = cyc + 3; ev.kind = 1; ev.data = w; ev.nbits = nbits;
        evq.push_back(ev);
        wait_clk(6);
    endtask

    task automatic strobe(input logic e, input logic o);
        ev_t ev;
        eom_in = e; ovf_in = o;
        ev.due = cyc + 1; ev.kind = 2; ev.data = {14'd0, e, o}; ev.nbits = 0;
        evq.push_back(ev);
        wait_clk(1);
        eom_in = 1'b0; ovf_in = 1'b0;
        wait_clk(2);
    endtask

    initial begin
        logic [15:0] got;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(1);
        // R1 reset state
        chk(int_n === 1'b1 && run === 1'b0 && start_pulse === 1'b0, "R1", "ctrl outputs",
            {29'd0, int_n, run, start_pulse}, 32'h4);
        chk(cmd_addr === 11'd0 && cmd_ctrl === 5'd0 && miso_oe === 1'b0, "R1", "cmd/oe",
            {15'd0, cmd_addr, cmd_ctrl, miso_oe}, 32'd0);
        wait_clk(3);

        // R2 plain command, run clear
        send_frame({5'b00110, 11'h155}, 16, got);
        chk(got === 16'h0000, "R9", "initial status", 32'(got), 32'h0);
        chk(cmd_addr === 11'h155 && cmd_ctrl === 5'b00110, "R2", "decoded fields",
            {16'd0, cmd_ctrl, cmd_addr}, {16'd0, 5'b00110, 11'h155});

        // R4 short and long frames discarded
        send_frame({5'b00001, 11'h0AA}, 15, got);
        chk(cmd_addr === 11'h155 && run === 1'b0, "R4", "15-bit frame kept", 32'(cmd_addr), 32'h155);
        send_frame({5'b00001, 11'h0AA}, 17, got);
        chk(cmd_addr === 11'h155 && run === 1'b0, "R4", "17-bit frame kept", 32'(cmd_addr), 32'h155);

        // R5 launch
        send_frame({5'b10001, 11'h3A5}, 16, got);
        chk(run === 1'b1 && cmd_addr === 11'h3A5, "R5", "run after launch", 32'(run), 32'd1);

        // R6 end of message
        strobe(1'b1, 1'b0);
        chk(run === 1'b0 && int_n === 1'b0, "R6", "eom ends op", {30'd0, run, int_n}, 32'd0);

        // R11 read flags, R8 clear
        send_frame({5'b00000, 11'h010}, 16, got);
        chk(got === {11'h3A5, 3'b000, 1'b1, 1'b0}, "R11", "status with eom",
            32'(got), 32'({11'h3A5, 3'b000, 1'b1, 1'b0}));
        chk(int_n === 1'b1, "R8", "int cleared", 32'(int_n), 32'd1);

        // R7 idle strobe ignored
        strobe(1'b1, 1'b1);
        chk(int_n === 1'b1 && run === 1'b0, "R7", "idle strobe", {30'd0, run, int_n}, 32'd1);
        send_frame({5'b00011, 11'h7FF}, 16, got);
        chk(got === {11'h010, 5'b00000}, "R7", "flags untouched", 32'(got), 32'({11'h010, 5'b0}));
        chk(run === 1'b1, "R5", "second launch", 32'(run), 32'd1);

        // R6 overflow, R11 read and relaunch in one frame
        strobe(1'b0, 1'b1);
        chk(int_n === 1'b0 && run === 1'b0, "R6", "ovf ends op", {30'd0, run, int_n}, 32'd0);
        send_frame({5'b00101, 11'h200}, 16, got);
        chk(got === {11'h7FF, 3'b000, 1'b0, 1'b1}, "R11", "status with ovf",
            32'(got), 32'({11'h7FF, 3'b000, 1'b0, 1'b1}));
        chk(run === 1'b1 && int_n === 1'b1, "R11", "relaunch in same frame", {30'd0, run, int_n}, 32'd3);

        // R5 stop by command, no interrupt
        send_frame({5'b00000, 11'h200}, 16, got);
        chk(got === {11'h200, 5'b00000}, "R9", "status layout", 32'(got), 32'({11'h200, 5'b0}));
        chk(run === 1'b0 && int_n === 1'b1, "R5", "stop no int", {30'd0, run, int_n}, 32'd1);

        // R6 both conditions at once
        send_frame({5'b00001, 11'h001}, 16, got);
        strobe(1'b1, 1'b1);
        send_frame({5'b00000, 11'h002}, 16, got);
        chk(got === {11'h001, 3'b000, 1'b1, 1'b1}, "R6", "both flags",
            32'(got), 32'({11'h001, 3'b000, 2'b11}));

        // R10 idle enable, R5 pulse count
        chk(miso_oe === 1'b0, "R10", "miso_oe idle", 32'(miso_oe), 32'd0);
        chk(pulses == 4, "R5", "start pulse count", 32'(pulses), 32'd4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule